// File: doc/BRIEF.md
# Dual-Group Tone Frequency Classifier

This block sits behind the two band-split comparators of a touch-tone receiver. Each comparator delivers a full-swing square wave: one carries the low (row) group tone, the other the high (column) group tone. The block times the interval between rising crossings of each wave in cycles of the reference clock. It sorts every measured period into one of the four nominal tones of its group, or into a hold zone, or rejects it. A group counts as valid once enough consecutive periods land in the same bin.

While both groups are valid, the block raises an early tone-present flag and presents a 4-bit key code for the row/column pair. An inhibit input suppresses the whole 1633 Hz column. The flag falls the cycle after either group loses validity. Guard-time steering, output latching towards a bus, and all analog processing sit outside this block.

The outputs are plain level signals with no handshake and no back-pressure. A consumer samples them whenever it likes. The code holds its last value while the flag is low.

Top module: `dtmf_pair_classifier`

## Requirements
- R1: After reset, `tone_present_o` is 0 and `key_code_o` is 0.
- R2: A tone whose frequency deviates from its nominal value by at most 1.5% plus 2 Hz is accepted. Nominal values are 697/770/852/941 Hz for rows 0 to 3 and 1209/1336/1477/1633 Hz for columns 0 to 3. A measured period of m cycles at clock rate CLK is accepted for frequency f when CLK/m lies within ±2.5% of f.
- R3: A period whose frequency CLK/m deviates by 3.5% or more from every nominal value of its group is rejected. Rejection clears that group's validity.
- R4: A group becomes valid only after `NEED` (default 4) consecutive measured periods fall in the same accept bin. The first crossing after reset or silence only starts timing.
- R5: A period in the hold zone of the current bin keeps the previous decision and leaves the streak unchanged. The hold zone is a deviation above 2.5% and below 3.5%.
- R6: If no rising crossing arrives before the count since the last crossing reaches a reject-length period of the group's lowest tone, that group becomes invalid.
- R7: `tone_present_o` is 1 exactly one cycle after both groups were valid (and the pair was not inhibited). It falls one cycle after either group loses validity.
- R8: The key code is 1 to 9 for digits 1 to 9, with row r and column c (c<3, r<3) giving 3r+c+1. Row 3 gives `*`=11, `0`=10 and `#`=12 in columns 0, 1 and 2. Column 3 gives A=13, B=14, C=15 for rows 0 to 2 and D=0 for row 3.
- R9: With `inhibit_i` high, a pair in column 3 does not raise `tone_present_o`, and the code keeps its previous value.
- R10: `key_code_o` changes only in a cycle where `tone_present_o` is 1; otherwise it holds the last detected pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock at `CLK_HZ` |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_sq_i | input | 1 | Low-group comparator square wave (asynchronous) |
| hi_sq_i | input | 1 | High-group comparator square wave (asynchronous) |
| inhibit_i | input | 1 | High suppresses the 1633 Hz column keys |
| tone_present_o | output | 1 | Early flag: both groups currently valid |
| key_code_o | output | 4 | Code of the last detected pair |

## Verification
Two functions can collide in one cycle. In the first, one group gains validity in the same cycle the other group drops it, whether by a rejected period or a timeout. The bench provokes this by switching one wave's period or silencing it while the other group's streak is still building. In the second, inhibit is raised while a column-3 pair is already valid or about to become valid. A behavioural model, driven by the same sampled inputs, predicts the flag and code on every clock. Any disagreement in the cycle where both events land counts as a failure. Phase-end checks also compare the settled flag and code against values worked out by hand for each key, for the hold zone, for rejection and for silence.

// File: rtl/tone_cls_pkg.sv
package tone_cls_pkg;

  localparam int NUM_BINS = 4;
  typedef logic [1:0] bin_t;

  // nominal frequency in Hz for group (0 = rows, 1 = columns) and bin index
  function automatic int nominal_hz(input int hi, input int b);
    int f;
    if (hi == 0) begin
      case (b)
        0:       f = 697;
        1:       f = 770;
        2:       f = 852;
        default: f = 941;
      endcase
    end else begin
      case (b)
        0:       f = 1209;
        1:       f = 1336;
        2:       f = 1477;
        default: f = 1633;
      endcase
    end
    return f;
  endfunction

  // floor(clk*1000 / (f*permille)): period in cycles at f scaled by permille/1000
  function automatic int period_floor(input longint clk_hz, input int f, input int permille);
    longint num, den;
    num = clk_hz * 64'd1000;
    den = longint'(f) * longint'(permille);
    return int'(num / den);
  endfunction

  function automatic int period_ceil(input longint clk_hz, input int f, input int permille);
    longint num, den;
    num = clk_hz * 64'd1000;
    den = longint'(f) * longint'(permille);
    return int'((num + den - 64'd1) / den);
  endfunction

  // row/column to key code
  function automatic logic [3:0] pair_code(input bin_t row, input bin_t col);
    logic [3:0] c;
    if (col == 2'd3) begin
      c = (row == 2'd3) ? 4'd0 : 4'(13 + int'(row));
    end else if (row == 2'd3) begin
      case (col)
        2'd0:    c = 4'd11;
        2'd1:    c = 4'd10;
        default: c = 4'd12;
      endcase
    end else begin
      c = 4'(3 * int'(row) + int'(col) + 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/sq_edge_sync.sv
module sq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sq_i,
  output logic rise_o
);

  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], sq_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  // a rising crossing is a single-cycle pulse
  p_rise_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/tone_bin_tracker.sv
module tone_bin_tracker
  import tone_cls_pkg::*;
#(
  parameter int CLK_HZ   = 3579545,
  parameter int HI_GROUP = 0,
  parameter int NEED     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  output logic ok_o,
  output bin_t bin_o
);

  localparam int TIMEOUT = period_ceil(CLK_HZ, nominal_hz(HI_GROUP, 0), 965);
  localparam int CNT_W   = $clog2(TIMEOUT + 1) + 1;
  localparam int STK_W   = $clog2(NEED + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [STK_W-1:0] STK_FULL = STK_W'(NEED);

  logic [CNT_W-1:0]    cnt_q;
  logic                seen_q;
  logic [STK_W-1:0]    stk_q;
  bin_t                cand_q;
  logic [31:0]         meas;
  logic [NUM_BINS-1:0] acc_hit;
  logic [NUM_BINS-1:0] gray_hit;
  bin_t                hit_bin;
  logic                timed_out;

  assign meas      = 32'(cnt_q);
  assign timed_out = meas >= 32'(TIMEOUT);

  // one accept window and one hold zone per nominal tone
  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    localparam int F      = nominal_hz(HI_GROUP, b);
    localparam int ACC_LO = period_ceil(CLK_HZ, F, 1025);
    localparam int ACC_HI = period_floor(CLK_HZ, F, 975);
    localparam int REJ_LO = period_floor(CLK_HZ, F, 1035);
    localparam int REJ_HI = period_ceil(CLK_HZ, F, 965);
    assign acc_hit[b]  = (meas >= 32'(ACC_LO)) && (meas <= 32'(ACC_HI));
    assign gray_hit[b] = (meas > 32'(REJ_LO)) && (meas < 32'(REJ_HI)) && !acc_hit[b];
  end

  always_comb begin
    hit_bin = '0;
    for (int b = NUM_BINS - 1; b >= 0; b--) begin
      if (acc_hit[b]) hit_bin = bin_t'(b);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      stk_q  <= '0;
      cand_q <= '0;
    end else if (rise_i) begin
      cnt_q  <= CNT_W'(1);
      seen_q <= 1'b1;
      if (seen_q) begin
        if (|acc_hit) begin
          if (stk_q != '0 && cand_q == hit_bin) begin
            if (stk_q != STK_FULL) stk_q <= stk_q + 1'b1;
          end else begin
            cand_q <= hit_bin;
            stk_q  <= STK_W'(1);
          end
        end else if (!(stk_q != '0 && gray_hit[cand_q])) begin
          stk_q <= '0;
        end
      end
    end else begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (timed_out)        stk_q <= '0;
    end
  end

  assign ok_o  = (stk_q == STK_FULL);
  assign bin_o = cand_q;

  // validity can only appear right after a measured crossing
  p_ok_after_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_o) |-> $past(rise_i));

  // a silent input past the longest period drops validity
  p_timeout_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (timed_out && !rise_i) |=> !ok_o);

  // between crossings a valid decision and its bin stay put
  p_hold_between_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_o && !rise_i && !timed_out) |=> (ok_o && $stable(bin_o)));

endmodule

// File: rtl/pair_flag_encoder.sv
module pair_flag_encoder
  import tone_cls_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lo_ok_i,
  input  bin_t       lo_bin_i,
  input  logic       hi_ok_i,
  input  bin_t       hi_bin_i,
  input  logic       inhibit_i,
  output logic       present_o,
  output logic [3:0] code_o
);

  localparam bin_t LAST_COL = bin_t'(NUM_BINS - 1);

  logic blocked;
  logic pair_ok;

  assign blocked = inhibit_i && (hi_bin_i == LAST_COL);
  assign pair_ok = lo_ok_i && hi_ok_i && !blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present_o <= 1'b0;
      code_o    <= 4'd0;
    end else begin
      present_o <= pair_ok;
      if (pair_ok) code_o <= pair_code(lo_bin_i, hi_bin_i);
    end
  end

  p_pair_needs_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
    present_o |-> $past(lo_ok_i && hi_ok_i));

  p_inhibit_col_r9: assert property (@(posedge clk) disable iff (!rst_n)
    present_o |-> !($past(inhibit_i) && $past(hi_bin_i) == LAST_COL));

  p_code_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_o) |-> present_o);

endmodule

// File: rtl/dtmf_pair_classifier.sv
module dtmf_pair_classifier
  import tone_cls_pkg::*;
#(
  parameter int CLK_HZ      = 3579545,
  parameter int NEED        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lo_sq_i,
  input  logic       hi_sq_i,
  input  logic       inhibit_i,
  output logic       tone_present_o,
  output logic [3:0] key_code_o
);

  localparam int NUM_GROUPS = 2;

  logic [NUM_GROUPS-1:0] sq_w;
  logic [NUM_GROUPS-1:0] rise_w;
  logic [NUM_GROUPS-1:0] ok_w;
  bin_t                  bin_w [NUM_GROUPS];

  assign sq_w = {hi_sq_i, lo_sq_i};

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    sq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .sq_i   (sq_w[g]),
      .rise_o (rise_w[g])
    );
    tone_bin_tracker #(.CLK_HZ(CLK_HZ), .HI_GROUP(g), .NEED(NEED)) u_trk (
      .clk    (clk),
      .rst_n  (rst_n),
      .rise_i (rise_w[g]),
      .ok_o   (ok_w[g]),
      .bin_o  (bin_w[g])
    );
  end

  pair_flag_encoder u_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .lo_ok_i   (ok_w[0]),
    .lo_bin_i  (bin_w[0]),
    .hi_ok_i   (ok_w[1]),
    .hi_bin_i  (bin_w[1]),
    .inhibit_i (inhibit_i),
    .present_o (tone_present_o),
    .code_o    (key_code_o)
  );

endmodule

// File: tb/dtmf_pair_classifier_test.sv
module dtmf_pair_classifier_test;

  localparam longint CLK = 357955;
  localparam int     NEED = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inhibit = 1'b0;
  logic [1:0] sq = 2'b00;
  logic tone_present;
  logic [3:0] key_code;

  int per [2] = '{0, 0};
  int ph  [2] = '{0, 0};
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dtmf_pair_classifier #(.CLK_HZ(int'(CLK)), .NEED(NEED)) uut (
    .clk(clk), .rst_n(rst_n), .lo_sq_i(sq[0]), .hi_sq_i(sq[1]),
    .inhibit_i(inhibit), .tone_present_o(tone_present), .key_code_o(key_code));

  // square-wave sources, rising crossing once every per[g] cycles
  always @(negedge clk) begin
    for (int g = 0; g < 2; g++) begin
      if (per[g] == 0) begin
        ph[g] = 0;
        sq[g] = 1'b0;
      end else begin
        sq[g] = (ph[g] < per[g] / 2);
        ph[g] = (ph[g] + 1 >= per[g]) ? 0 : ph[g] + 1;
      end
    end
  end

  function automatic int ref_hz(int g, int b);
    int rows [4] = '{697, 770, 852, 941};
    int cols [4] = '{1209, 1336, 1477, 1633};
    return (g == 0) ? rows[b] : cols[b];
  endfunction

  function automatic bit accepts(longint m, int f);
    return (m * f * 1025 >= CLK * 1000) && (m * f * 975 <= CLK * 1000);
  endfunction

  function automatic bit rejects(longint m, int f);
    return (m * f * 1035 <= CLK * 1000) || (m * f * 965 >= CLK * 1000);
  endfunction

  function automatic int ref_code(int r, int c);
    string grid [4] = '{"123A", "456B", "789C", "*0#D"};
    byte ch;
    ch = grid[r][c];
    case (ch)
      "*": return 11;
      "#": return 12;
      "0": return 10;
      "A": return 13;
      "B": return 14;
      "C": return 15;
      "D": return 0;
      default: return int'(ch) - int'("0");
    endcase
  endfunction

  // behavioural reference
  longint m_cnt [2];
  bit     m_seen [2];
  int     m_stk [2];
  int     m_cand [2];
  bit     m_hist [2][3];
  bit     m_pres;
  int     m_code;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < 2; g++) begin
        m_cnt[g] = 0; m_seen[g] = 0; m_stk[g] = 0; m_cand[g] = 0;
        m_hist[g] = '{0, 0, 0};
      end
      m_pres = 0;
      m_code = 0;
    end else begin
      bit pn;
      pn = (m_stk[0] >= NEED) && (m_stk[1] >= NEED) && !(inhibit && m_cand[1] == 3);
      if (pn) m_code = ref_code(m_cand[0], m_cand[1]);
      m_pres = pn;
      for (int g = 0; g < 2; g++) begin
        if (m_hist[g][1] && !m_hist[g][2]) begin
          if (m_seen[g]) begin
            int hit;
            hit = -1;
            for (int b = 3; b >= 0; b--) if (accepts(m_cnt[g], ref_hz(g, b))) hit = b;
            if (hit >= 0) begin
              if (m_stk[g] > 0 && m_cand[g] == hit) m_stk[g] = (m_stk[g] < NEED) ? m_stk[g] + 1 : NEED;
              else begin m_cand[g] = hit; m_stk[g] = 1; end
            end else if (!(m_stk[g] > 0 && !rejects(m_cnt[g], ref_hz(g, m_cand[g])))) begin
              m_stk[g] = 0;
            end
          end
          m_seen[g] = 1;
          m_cnt[g] = 1;
        end else begin
          if (m_cnt[g] * ref_hz(g, 0) * 965 >= CLK * 1000) m_stk[g] = 0;
          m_cnt[g] = m_cnt[g] + 1;
        end
        m_hist[g][2] = m_hist[g][1];
        m_hist[g][1] = m_hist[g][0];
        m_hist[g][0] = sq[g];
      end
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (tone_present !== m_pres) begin
        errors++;
        $display("FAIL R7 cycle flag act=%0d exp=%0d at %0t", tone_present, m_pres, $time);
      end
      checks++;
      if (int'(key_code) != m_code) begin
        errors++;
        $display("FAIL R8 cycle code act=%0d exp=%0d at %0t", key_code, m_code, $time);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic play(input int lo, input int hi, input int n);
    @(negedge clk);
    per[0] = lo;
    per[1] = hi;
    wait_cycles(n);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog act=%0d exp=%0d", 0, 1);
    finish_run();
  end

  initial begin
    wait_cycles(5);
    check("R1 flag after reset", tone_present, 0);
    check("R1 code after reset", key_code, 0);
    @(negedge clk) rst_n = 1'b1;

    // key 5 from silence: row 770, column 1336
    play(465, 268, 1600);
    check("R4 streak not complete", tone_present, 0);
    wait_cycles(2000);
    check("R2 key 5 flag", tone_present, 1);
    check("R8 key 5 code", key_code, 5);

    // key 1 with row +1.7% and column on nominal
    play(505, 296, 3600);
    check("R2 deviated key 1 flag", tone_present, 1);
    check("R8 key 1 code", key_code, 1);

    play(380, 268, 3600);
    check("R8 key 0 code", key_code, 10);
    play(380, 296, 3600);
    check("R8 key star code", key_code, 11);
    // column 1477 at -1.48%
    play(380, 246, 3600);
    check("R2 deviated hash flag", tone_present, 1);
    check("R8 key hash code", key_code, 12);

    // inhibited column 3
    inhibit = 1'b1;
    play(465, 219, 3600);
    check("R9 inhibited flag", tone_present, 0);
    check("R9 inhibited code held", key_code, 12);
    inhibit = 1'b0;
    wait_cycles(10);
    check("R9 key B flag after release", tone_present, 1);
    check("R8 key B code", key_code, 14);
    play(514, 219, 3600);
    check("R8 key A code", key_code, 13);
    play(380, 219, 3600);
    check("R8 key D code", key_code, 0);

    // key 7 then hold zone then reject on the row
    play(420, 296, 3600);
    check("R8 key 7 code", key_code, 7);
    play(433, 296, 3600);
    check("R5 hold zone flag", tone_present, 1);
    check("R5 hold zone code", key_code, 7);
    play(440, 296, 3600);
    check("R3 rejected row flag", tone_present, 0);
    check("R10 code held after drop", key_code, 7);

    // valid again, then the row falls silent
    play(420, 296, 3600);
    check("R2 key 7 again", tone_present, 1);
    play(0, 296, 800);
    check("R6 silent row drops flag", tone_present, 0);
    check("R7 column alone", tone_present, 0);

    // row alone
    play(465, 0, 3600);
    check("R7 row alone", tone_present, 0);
    check("R10 code held while idle", key_code, 7);

    finish_run();
  end

endmodule